// File: doc/BRIEF.md
# SPI Master Controller with Completion and Collision Flags

This block is an SPI master with a register-style interface on the processor side. When the processor writes a byte to the data port while the block is idle and in master mode, the block shifts that byte out on `mosi`, most significant bit first. At the same time it shifts a byte in from `miso`, using SPI mode 0: `sck` idles low, `mosi` moves on falling edges and `miso` is sampled on rising edges. When the transfer ends, the received byte is available on the data read port.

`sck` is derived from the system clock. Two rate-select inputs and a double-speed bit choose one of eight divisors. The double-speed bit lives in the status register. Two sticky flags report on transfers: a completion flag and a write-collision flag. Software clears them with a two-step handshake: it reads status while the flag is set, and then reads or writes the data port. The completion flag can also be cleared by acknowledging the interrupt. An active-low select input is monitored while the block is master. When that input is used as an input and is pulled low, the block:
- aborts the transfer,
- sets the completion flag,
- leaves master mode until the master-select control is toggled.

Top module: `spi_master_ctl`

## Requirements
- R1: After reset, `stat_rdata`, `data_rdata`, `sck` and `irq` are all zero, and `master_mode` follows `ctl_master`.
- R2: A `data_wr` while idle and in master mode sends `data_wdata` MSB first in mode 0. `sck` idles low, `mosi` is stable across every rising edge, and `miso` is sampled on rising edges. After completion the received byte appears on `data_rdata`.
- R3: With the double-speed bit clear, `ctl_rate` values 0, 1, 2 and 3 give an `sck` period of 4, 16, 64 and 128 system clocks. The completion flag rises 8 periods after the write edge.
- R4: With the double-speed bit set, `ctl_rate` values 0, 1, 2 and 3 give an `sck` period of 2, 8, 32 and 64 system clocks, with the same 8-period transfer length.
- R5: Status bit 7 (completion flag) is set when a transfer finishes. `irq` is high exactly while that flag and `ctl_irq_en` are both high.
- R6: A `data_wr` during a transfer sets status bit 6 (collision flag). The written byte is discarded, and the bytes sent and received are unchanged.
- R7: A `stat_rd` while a flag is set, followed by a later `data_rd` or `data_wr`, clears each flag that was set at that read.
- R8: A data-port access with no arming status read beforehand leaves both flags unchanged.
- R9: A pulse on `irq_ack` clears the completion flag and leaves the collision flag as it is.
- R10: While in master mode with `ss_is_input` high, `ss_n` low does four things: it sets the completion flag, aborts the transfer with `sck` low, drops `master_mode`, and blocks new transfers. It does so until `ctl_master` goes low and then high again.
- R11: With `ss_is_input` low, `ss_n` has no effect and transfers complete normally.
- R12: Status bits 5 to 1 read as zero. Bit 0 is the double-speed bit, written through `stat_wr` with `stat_wdata_dbl`, and reads back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_master | input | 1 | Master-select control |
| ctl_irq_en | input | 1 | Interrupt enable control |
| ctl_rate | input | 2 | Clock rate select |
| ss_is_input | input | 1 | Select pin is used as an input |
| ss_n | input | 1 | Active-low select input |
| data_wr | input | 1 | Data port write strobe |
| data_rd | input | 1 | Data port read strobe |
| data_wdata | input | 8 | Byte to transmit |
| data_rdata | output | 8 | Last received byte |
| stat_rd | input | 1 | Status read strobe |
| stat_wr | input | 1 | Status write strobe |
| stat_wdata_dbl | input | 1 | Double-speed value for status write |
| stat_rdata | output | 8 | Status: bit7 done, bit6 collision, bit0 double-speed |
| irq | output | 1 | Interrupt request |
| irq_ack | input | 1 | Interrupt acknowledge pulse |
| master_mode | output | 1 | Block is currently acting as master |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
The assertions check on every cycle the local rules of the block:
- `sck` stays low whenever no transfer is active.
- `mosi` holds steady across each rising edge.
- Each rise of a flag traces back to a completion, select-fault or collision event the cycle before.
- A set completion flag holds unless it was armed or acknowledged.
- A select fault leaves the block idle and out of master mode.

Only the bench's scenarios can show the end-to-end behaviour:
- the exact transfer length for each of the eight divisor settings;
- the bit order and content of the exchanged bytes;
- that a colliding write leaves the shifted data untouched;
- that master mode returns only after the control is toggled.

// File: rtl/spi_master_pkg.sv
package spi_master_pkg;

  // Largest half period of sck in system clocks (divisor 128 / 2)
  localparam int unsigned MAX_HALF = 64;
  localparam int unsigned CNT_W    = $clog2(MAX_HALF);

  // Full sck period in system clocks for a given speed setting
  function automatic int unsigned sck_divisor(input logic dbl, input logic [1:0] rate);
    int unsigned base;
    case (rate)
      2'd0:    base = 4;
      2'd1:    base = 16;
      2'd2:    base = 64;
      default: base = 128;
    endcase
    return dbl ? (base >> 1) : base;
  endfunction

  // Clocks per sck phase
  function automatic int unsigned half_period(input logic dbl, input logic [1:0] rate);
    return sck_divisor(dbl, rate) >> 1;
  endfunction

endpackage

// File: rtl/spi_sck_gen.sv
module spi_sck_gen #(
  parameter int unsigned DATA_W = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       abort,
  input  logic       dbl,
  input  logic [1:0] rate,
  output logic       busy,
  output logic       sck,
  output logic       rise_evt,
  output logic       fall_evt,
  output logic       last_evt
);
  import spi_master_pkg::*;

  localparam int unsigned EDGES  = 2 * DATA_W;
  localparam int unsigned EDGE_W = $clog2(EDGES);
  localparam logic [EDGE_W-1:0] LAST_EDGE = EDGE_W'(EDGES - 1);

  logic [CNT_W-1:0]  phase_cnt;
  logic [CNT_W-1:0]  half_m1;
  logic [EDGE_W-1:0] edge_idx;
  logic              toggle;

  assign toggle   = busy && (phase_cnt == half_m1);
  assign rise_evt = toggle && !sck;
  assign fall_evt = toggle && sck;
  assign last_evt = toggle && (edge_idx == LAST_EDGE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      sck       <= 1'b0;
      phase_cnt <= '0;
      half_m1   <= '0;
      edge_idx  <= '0;
    end else if (abort) begin
      busy      <= 1'b0;
      sck       <= 1'b0;
      phase_cnt <= '0;
      edge_idx  <= '0;
    end else if (start) begin
      busy      <= 1'b1;
      sck       <= 1'b0;
      phase_cnt <= '0;
      edge_idx  <= '0;
      half_m1   <= CNT_W'(half_period(dbl, rate) - 1);
    end else if (busy) begin
      if (toggle) begin
        phase_cnt <= '0;
        sck       <= ~sck;
        edge_idx  <= edge_idx + 1'b1;
        if (edge_idx == LAST_EDGE) busy <= 1'b0;
      end else begin
        phase_cnt <= phase_cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/spi_shift_unit.sv
module spi_shift_unit #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DATA_W-1:0] tx_byte,
  input  logic              rise_evt,
  input  logic              fall_evt,
  input  logic              done_evt,
  input  logic              miso,
  output logic              mosi,
  output logic [DATA_W-1:0] rx_byte
);

  logic [DATA_W-1:0] shreg;
  logic              miso_q;
  logic [DATA_W-1:0] shifted;

  assign shifted = {shreg[DATA_W-2:0], miso_q};
  assign mosi    = shreg[DATA_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg   <= '0;
      miso_q  <= 1'b0;
      rx_byte <= '0;
    end else begin
      if (start)         shreg  <= tx_byte;
      else if (fall_evt) shreg  <= shifted;
      if (rise_evt)      miso_q <= miso;
      if (done_evt)      rx_byte <= shifted;
    end
  end

endmodule

// File: rtl/spi_status_flags.sv
module spi_status_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic done_evt,
  input  logic fault_evt,
  input  logic coll_evt,
  input  logic stat_rd,
  input  logic data_acc,
  input  logic irq_ack,
  output logic done_flag,
  output logic coll_flag,
  output logic arm_done,
  output logic arm_coll
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_flag <= 1'b0;
      coll_flag <= 1'b0;
      arm_done  <= 1'b0;
      arm_coll  <= 1'b0;
    end else begin
      if (done_evt || fault_evt)                   done_flag <= 1'b1;
      else if ((data_acc && arm_done) || irq_ack)  done_flag <= 1'b0;

      if (coll_evt)                   coll_flag <= 1'b1;
      else if (data_acc && arm_coll)  coll_flag <= 1'b0;

      if (stat_rd) begin
        arm_done <= done_flag;
        arm_coll <= coll_flag;
      end else if (data_acc) begin
        arm_done <= 1'b0;
        arm_coll <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/spi_master_ctl.sv
module spi_master_ctl #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_master,
  input  logic              ctl_irq_en,
  input  logic [1:0]        ctl_rate,
  input  logic              ss_is_input,
  input  logic              ss_n,
  input  logic              data_wr,
  input  logic              data_rd,
  input  logic [DATA_W-1:0] data_wdata,
  output logic [DATA_W-1:0] data_rdata,
  input  logic              stat_rd,
  input  logic              stat_wr,
  input  logic              stat_wdata_dbl,
  output logic [7:0]        stat_rdata,
  output logic              irq,
  input  logic              irq_ack,
  output logic              master_mode,
  output logic              sck,
  output logic              mosi,
  input  logic              miso
);

  // Named internal events, visible to the bound checker
  logic busy_w, start_w, abort_w, fault_w, coll_w, done_w;
  logic rise_w, fall_w, data_acc_w;
  logic done_flag_w, coll_flag_w, arm_done_w, arm_coll_w;
  logic dbl_q, master_ok_q, master_prev_q;

  assign master_mode = ctl_master && master_ok_q;
  assign fault_w     = master_mode && ss_is_input && !ss_n;
  assign start_w     = data_wr && master_mode && !busy_w && !fault_w;
  assign coll_w      = data_wr && busy_w;
  assign abort_w     = fault_w || (busy_w && !master_mode);
  assign data_acc_w  = data_wr || data_rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dbl_q         <= 1'b0;
      master_ok_q   <= 1'b1;
      master_prev_q <= 1'b0;
    end else begin
      if (stat_wr) dbl_q <= stat_wdata_dbl;
      master_prev_q <= ctl_master;
      if (fault_w)                          master_ok_q <= 1'b0;
      else if (ctl_master && !master_prev_q) master_ok_q <= 1'b1;
    end
  end

  spi_sck_gen #(.DATA_W(DATA_W)) u_sck (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start_w),
    .abort    (abort_w),
    .dbl      (dbl_q),
    .rate     (ctl_rate),
    .busy     (busy_w),
    .sck      (sck),
    .rise_evt (rise_w),
    .fall_evt (fall_w),
    .last_evt (done_w)
  );

  spi_shift_unit #(.DATA_W(DATA_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start_w),
    .tx_byte  (data_wdata),
    .rise_evt (rise_w),
    .fall_evt (fall_w),
    .done_evt (done_w),
    .miso     (miso),
    .mosi     (mosi),
    .rx_byte  (data_rdata)
  );

  spi_status_flags u_flags (
    .clk       (clk),
    .rst_n     (rst_n),
    .done_evt  (done_w),
    .fault_evt (fault_w),
    .coll_evt  (coll_w),
    .stat_rd   (stat_rd),
    .data_acc  (data_acc_w),
    .irq_ack   (irq_ack),
    .done_flag (done_flag_w),
    .coll_flag (coll_flag_w),
    .arm_done  (arm_done_w),
    .arm_coll  (arm_coll_w)
  );

  assign stat_rdata = {done_flag_w, coll_flag_w, 5'b00000, dbl_q};
  assign irq        = done_flag_w && ctl_irq_en;

endmodule

// File: rtl/spi_master_ctl_chk.sv
module spi_master_ctl_chk (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic sck,
  input logic mosi,
  input logic done_evt,
  input logic fault_evt,
  input logic data_wr,
  input logic irq_ack,
  input logic arm_done,
  input logic done_flag,
  input logic coll_flag,
  input logic master_mode
);

  AST_SCK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sck);                                                 // R2
  AST_MOSI_STEADY_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sck) |-> $stable(mosi));                                   // R2
  AST_DONE_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_flag) |-> $past(done_evt || fault_evt));              // R5
  AST_COLL_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(coll_flag) |-> $past(data_wr && busy));                    // R6
  AST_DONE_HELD_UNARMED: assert property (@(posedge clk) disable iff (!rst_n)
    (done_flag && !arm_done && !irq_ack) |=> done_flag);             // R8
  AST_FAULT_EXITS_MASTER: assert property (@(posedge clk) disable iff (!rst_n)
    fault_evt |=> (!master_mode && !busy));                          // R10

endmodule

bind spi_master_ctl spi_master_ctl_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .busy        (busy_w),
  .sck         (sck),
  .mosi        (mosi),
  .done_evt    (done_w),
  .fault_evt   (fault_w),
  .data_wr     (data_wr),
  .irq_ack     (irq_ack),
  .arm_done    (arm_done_w),
  .done_flag   (done_flag_w),
  .coll_flag   (coll_flag_w),
  .master_mode (master_mode)
);

// File: tb/spi_master_ctl_test.sv
module spi_master_ctl_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ctl_master = 1'b1, ctl_irq_en = 1'b0;
  logic [1:0] ctl_rate = 2'd0;
  logic       ss_is_input = 1'b0, ss_n = 1'b1;
  logic       data_wr = 1'b0, data_rd = 1'b0;
  logic [7:0] data_wdata = 8'h00;
  logic [7:0] data_rdata;
  logic       stat_rd = 1'b0, stat_wr = 1'b0, stat_wdata_dbl = 1'b0;
  logic [7:0] stat_rdata;
  logic       irq, irq_ack = 1'b0, master_mode, sck, mosi;
  logic       miso = 1'b0;

  int checks = 0, failures = 0;
  logic [7:0] slv_sh, tx_seen;
  int sck_rises = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_master_ctl uut (
    .clk(clk), .rst_n(rst_n), .ctl_master(ctl_master), .ctl_irq_en(ctl_irq_en),
    .ctl_rate(ctl_rate), .ss_is_input(ss_is_input), .ss_n(ss_n),
    .data_wr(data_wr), .data_rd(data_rd), .data_wdata(data_wdata),
    .data_rdata(data_rdata), .stat_rd(stat_rd), .stat_wr(stat_wr),
    .stat_wdata_dbl(stat_wdata_dbl), .stat_rdata(stat_rdata), .irq(irq),
    .irq_ack(irq_ack), .master_mode(master_mode), .sck(sck), .mosi(mosi),
    .miso(miso)
  );

  // Simple mode-0 slave: captures mosi on rise, advances miso on fall
  always @(posedge sck) begin
    tx_seen = {tx_seen[6:0], mosi};
    sck_rises = sck_rises + 1;
  end
  always @(negedge sck) begin
    slv_sh = {slv_sh[6:0], 1'b0};
    miso   = slv_sh[7];
  end

  // Vector: {dbl, rate[1:0], tx[7:0], rx[7:0]}
  localparam logic [18:0] VEC [8] = '{
    {1'b0, 2'd0, 8'hA5, 8'h5A}, {1'b0, 2'd1, 8'h3C, 8'hC3},
    {1'b0, 2'd2, 8'h01, 8'h80}, {1'b0, 2'd3, 8'hFF, 8'h00},
    {1'b1, 2'd0, 8'h80, 8'h01}, {1'b1, 2'd1, 8'h69, 8'h96},
    {1'b1, 2'd2, 8'h00, 8'hFF}, {1'b1, 2'd3, 8'hD2, 8'h2D}
  };

  function automatic int exp_period(input logic dbl, input logic [1:0] rate);
    int p;
    p = (rate == 2'd3) ? 128 : (4 << (2 * rate));
    if (dbl) p = p / 2;
    return p;
  endfunction

  task automatic check_eq(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic pulse(ref logic s);
    @(negedge clk) s = 1'b1;
    @(negedge clk) s = 1'b0;
  endtask

  task automatic set_dbl(input logic v);
    @(negedge clk) begin stat_wr = 1'b1; stat_wdata_dbl = v; end
    @(negedge clk) stat_wr = 1'b0;
  endtask

  task automatic arm_and_clear();
    pulse(stat_rd);
    pulse(data_rd);
  endtask

  task automatic start_xfer(input logic [7:0] tx, input logic [7:0] rx);
    @(negedge clk) begin
      slv_sh = rx; miso = rx[7]; tx_seen = 8'h00;
      data_wdata = tx; data_wr = 1'b1;
    end
    @(negedge clk) data_wr = 1'b0;
  endtask

  task automatic wait_done(output int cycles);
    cycles = 0;
    while (!stat_rdata[7] && cycles < 3000) begin
      @(negedge clk) cycles++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int cyc;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check_eq("R1 status", stat_rdata, 8'h00);
    check_eq("R1 rdata", data_rdata, 8'h00);
    check_eq("R1 sck", sck, 0);
    check_eq("R1 irq", irq, 0);
    check_eq("R1 master", master_mode, 1);

    // R12 status bit layout
    set_dbl(1'b1);
    check_eq("R12 dbl set", stat_rdata, 8'h01);
    set_dbl(1'b0);
    check_eq("R12 dbl clr", stat_rdata, 8'h00);

    // Table walk: R2, R3, R4, R7
    foreach (VEC[i]) begin
      logic d; logic [1:0] r; logic [7:0] tx, rx;
      {d, r, tx, rx} = VEC[i];
      set_dbl(d);
      ctl_rate = r;
      start_xfer(tx, rx);
      wait_done(cyc);
      check_eq(d ? "R4 length" : "R3 length", cyc, 8 * exp_period(d, r));
      check_eq("R2 mosi bits", tx_seen, tx);
      check_eq("R2 rx byte", data_rdata, rx);
      arm_and_clear();
      check_eq("R7 clear done", stat_rdata[7], 0);
    end

    // Collision, irq, unarmed access, ack: R5 R6 R8 R9 R7
    ctl_irq_en = 1'b1;
    set_dbl(1'b1);
    ctl_rate = 2'd0;
    start_xfer(8'hA5, 8'h3C);
    repeat (2) @(negedge clk);
    data_wdata = 8'hFF;
    pulse(data_wr);
    check_eq("R6 coll flag", stat_rdata[6], 1);
    wait_done(cyc);
    check_eq("R6 tx kept", tx_seen, 8'hA5);
    check_eq("R6 rx kept", data_rdata, 8'h3C);
    check_eq("R5 irq high", irq, 1);
    pulse(data_rd);
    check_eq("R8 flags held", stat_rdata[7:6], 2'b11);
    pulse(irq_ack);
    check_eq("R9 ack flags", stat_rdata[7:6], 2'b01);
    check_eq("R9 irq low", irq, 0);
    arm_and_clear();
    check_eq("R7 coll clear", stat_rdata, 8'h01);
    ctl_irq_en = 1'b0;
    start_xfer(8'h11, 8'h22);
    wait_done(cyc);
    check_eq("R5 flag no irq", {stat_rdata[7], irq}, 2'b10);
    arm_and_clear();

    // Select fault: R10
    ss_is_input = 1'b1;
    set_dbl(1'b0);
    ctl_rate = 2'd3;
    start_xfer(8'hC3, 8'h3C);
    repeat (20) @(negedge clk);
    ss_n = 1'b0;
    @(negedge clk);
    check_eq("R10 flag", stat_rdata[7], 1);
    check_eq("R10 sck low", sck, 0);
    check_eq("R10 master off", master_mode, 0);
    cyc = sck_rises;
    data_wdata = 8'h77;
    pulse(data_wr);
    repeat (300) @(negedge clk);
    check_eq("R10 no transfer", sck_rises, cyc);
    check_eq("R10 no coll", stat_rdata[6], 0);
    ss_n = 1'b1;
    arm_and_clear();
    check_eq("R10 still off", master_mode, 0);
    @(negedge clk) ctl_master = 1'b0;
    @(negedge clk) ctl_master = 1'b1;
    @(negedge clk);
    check_eq("R10 re-enabled", master_mode, 1);

    // Select ignored when not an input: R11
    ss_is_input = 1'b0;
    ss_n = 1'b0;
    set_dbl(1'b1);
    ctl_rate = 2'd0;
    start_xfer(8'h5E, 8'hE5);
    wait_done(cyc);
    check_eq("R11 length", cyc, 16);
    check_eq("R11 rx", data_rdata, 8'hE5);
    check_eq("R11 master kept", master_mode, 1);
    ss_n = 1'b1;

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule